// File: doc/BRIEF.md
# Programmable DRAM Address Multiplexer

This block turns a 24-bit CPU byte address into the signals for an asynchronous DRAM array of four banks. It produces a bank select, a row address and a column address on a shared multiplexed bus of up to 11 lines. Each bank has its own chip size setting of 64k, 256k, 1M or 4M. That setting decides how many multiplexed lines carry address information for the bank. Bank selection uses two bits in the middle of the CPU address, not its top bits.

A single access runs as follows. The row address goes out with the row strobe low. After a set number of cycles the column address goes out and the column strobe goes low. Both strobes are held for set counts, then released together, and a short precharge gap follows. The per-bank size settings sit in a small register file. Writes to it are taken only while no access is in flight.

Because a smaller chip does not connect the upper multiplexed lines, those lines are forced to zero. A CPU address whose only row bit lies above a chip's line count therefore lands on row 0. A sizing routine uses this aliasing to find the chip size.

Top module: `dram_addr_mux`

## Requirements
- R1: After synchronous reset `ras_n` and `cas_n` are 1, `dram_ma` is 0, `acc_done` is 0, `req_ready` is 1, and every bank is set to the 4M size (code 3).
- R2: `dram_bank` during an access equals CPU address bits [12:11]: 00 gives bank 0, 01 bank 1, 10 bank 2, 11 bank 3.
- R3: With the 4M size (code 3), the row phase drives CPU bits [23:13] on `dram_ma[10:0]` and the column phase drives CPU bits [10:0].
- R4: Size codes 0, 1 and 2 (64k, 256k, 1M) use n = 8, 9 and 10 lines. The row is CPU bits [13+n-1:13], the column is CPU bits [n-1:0], and `dram_ma` lines at n and above are 0. An address whose only row bit lies above n therefore gives row 0.
- R5: An accepted request (`req_valid` high while `req_ready` is high at a rising edge) pulls `ras_n` low on that edge, with the row on `dram_ma`. RCD_CYC cycles later the column appears with `cas_n` low. `cas_n` stays low for CAS_CYC cycles. `cas_n` is never low while `ras_n` is high, and `dram_ma` is 0 whenever both strobes are high.
- R6: `ras_n` and `cas_n` rise together. `acc_done` is high for exactly that one cycle. `req_ready` returns PRE_CYC cycles later.
- R7: While `req_ready` is low, `req_valid` has no effect: no second strobe sequence starts. While `req_ready` is high both strobes are high.
- R8: A write (`cfg_we` high while `req_ready` is high) sets the size code `cfg_size` for bank `cfg_bank` for all later accesses. A write while `req_ready` is low is ignored.
- R9: Each bank keeps its own size independently of the others, and `dram_bank` holds steady for the whole time `ras_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request |
| req_addr | input | 24 | CPU byte address of the request |
| req_ready | output | 1 | High when idle and able to take a request or configuration write |
| cfg_we | input | 1 | Size configuration write strobe |
| cfg_bank | input | 2 | Bank whose size is written |
| cfg_size | input | 2 | Size code: 0 64k, 1 256k, 2 1M, 3 4M |
| dram_ma | output | 11 | Multiplexed row/column address |
| dram_bank | output | 2 | Bank select for the current access |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| acc_done | output | 1 | One-cycle pulse when the strobes are released |

## Verification
The assertions assume that reset is held from time zero until the first clock edges have passed. They also assume that the inputs change only between clock edges, so a request and a configuration write are each seen at exactly one edge. The bench drives all inputs on the falling edge and keeps reset high for several cycles. Some requests and configuration writes are raised on purpose while an access is in flight. The bench then observes, at the ports, that no extra strobe sequence started and that the next access to the same bank still decodes with the old size.

// File: rtl/dram_mux_pkg.sv
package dram_mux_pkg;

  typedef enum logic [1:0] {
    CHIP_64K  = 2'd0,
    CHIP_256K = 2'd1,
    CHIP_1M   = 2'd2,
    CHIP_4M   = 2'd3
  } chip_size_e;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_ROW  = 2'd1,
    SEQ_COL  = 2'd2,
    SEQ_PRE  = 2'd3
  } seq_state_e;

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/dram_bank_cfg.sv
module dram_bank_cfg
  import dram_mux_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_allow,
  input  logic [BANK_W-1:0] wr_bank,
  input  logic [1:0]        wr_size,
  input  logic [BANK_W-1:0] rd_bank,
  output chip_size_e        rd_size
);

  chip_size_e size_q [NUM_BANKS];

  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      always_ff @(posedge clk) begin
        if (rst) begin
          size_q[b] <= CHIP_4M;
        end else if (wr_en && wr_allow && (wr_bank == BANK_W'(b))) begin
          size_q[b] <= chip_size_e'(wr_size);
        end
      end
    end
  endgenerate

  assign rd_size = size_q[rd_bank];

endmodule

// File: rtl/dram_addr_split.sv
module dram_addr_split
  import dram_mux_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int MA_W      = 11,
  parameter int ROW_LSB   = 13,
  parameter int BANK_LSB  = 11,
  parameter int BANK_W    = 2,
  parameter int MIN_LINES = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  chip_size_e        size,
  output logic [MA_W-1:0]   row,
  output logic [MA_W-1:0]   col,
  output logic [BANK_W-1:0] bank
);

  localparam int ROW_MSB = ROW_LSB + MA_W - 1;

  logic [MA_W-1:0] line_en;
  logic [MA_W-1:0] row_full;
  logic [MA_W-1:0] col_full;
  int              n_lines;

  assign n_lines = MIN_LINES + int'(size);

  // One enable per multiplexed line: lines above the chip's count stay 0.
  generate
    for (genvar i = 0; i < MA_W; i++) begin : g_line
      assign line_en[i] = (i < n_lines);
    end
  endgenerate

  assign row_full = addr[ROW_MSB:ROW_LSB];
  assign col_full = addr[MA_W-1:0];
  assign row      = row_full & line_en;
  assign col      = col_full & line_en;
  assign bank     = addr[BANK_LSB +: BANK_W];

endmodule

// File: rtl/dram_strobe_seq.sv
module dram_strobe_seq
  import dram_mux_pkg::*;
#(
  parameter int MA_W    = 11,
  parameter int RCD_CYC = 2,
  parameter int CAS_CYC = 2,
  parameter int PRE_CYC = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [MA_W-1:0] row,
  input  logic [MA_W-1:0] col,
  output logic            ready,
  output logic [MA_W-1:0] ma,
  output logic            ras_n,
  output logic            cas_n,
  output logic            done
);

  localparam int MAX_CYC = max3(RCD_CYC, CAS_CYC, PRE_CYC);
  localparam int CNT_W   = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

  seq_state_e      state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [MA_W-1:0]  col_q;
  logic             cnt_zero;

  assign cnt_zero = (cnt_q == '0);
  assign ready    = (state_q == SEQ_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
      col_q   <= '0;
      ma      <= '0;
      ras_n   <= 1'b1;
      cas_n   <= 1'b1;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state_q)
        SEQ_IDLE: begin
          if (start) begin
            state_q <= SEQ_ROW;
            ma      <= row;
            col_q   <= col;
            ras_n   <= 1'b0;
            cnt_q   <= CNT_W'(RCD_CYC - 1);
          end
        end
        SEQ_ROW: begin
          if (cnt_zero) begin
            state_q <= SEQ_COL;
            ma      <= col_q;
            cas_n   <= 1'b0;
            cnt_q   <= CNT_W'(CAS_CYC - 1);
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        SEQ_COL: begin
          if (cnt_zero) begin
            state_q <= SEQ_PRE;
            ma      <= '0;
            ras_n   <= 1'b1;
            cas_n   <= 1'b1;
            done    <= 1'b1;
            cnt_q   <= CNT_W'(PRE_CYC - 1);
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        SEQ_PRE: begin
          if (cnt_zero) begin
            state_q <= SEQ_IDLE;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dram_addr_mux.sv
module dram_addr_mux
  import dram_mux_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int MA_W      = 11,
  parameter int NUM_BANKS = 4,
  parameter int BANK_LSB  = 11,
  parameter int MIN_LINES = 8,
  parameter int RCD_CYC   = 2,
  parameter int CAS_CYC   = 2,
  parameter int PRE_CYC   = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         req_valid,
  input  logic [ADDR_W-1:0]            req_addr,
  output logic                         req_ready,
  input  logic                         cfg_we,
  input  logic [$clog2(NUM_BANKS)-1:0] cfg_bank,
  input  logic [1:0]                   cfg_size,
  output logic [MA_W-1:0]              dram_ma,
  output logic [$clog2(NUM_BANKS)-1:0] dram_bank,
  output logic                         ras_n,
  output logic                         cas_n,
  output logic                         acc_done
);

  localparam int BANK_W  = $clog2(NUM_BANKS);
  localparam int ROW_LSB = BANK_LSB + BANK_W;

  logic [BANK_W-1:0] req_bank;
  chip_size_e        req_size;
  logic [MA_W-1:0]   req_row;
  logic [MA_W-1:0]   req_col;
  logic              start;
  logic [BANK_W-1:0] bank_q;

  assign start = req_valid && req_ready;

  dram_bank_cfg #(
    .NUM_BANKS (NUM_BANKS),
    .BANK_W    (BANK_W)
  ) u_cfg (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (cfg_we),
    .wr_allow (req_ready),
    .wr_bank  (cfg_bank),
    .wr_size  (cfg_size),
    .rd_bank  (req_bank),
    .rd_size  (req_size)
  );

  dram_addr_split #(
    .ADDR_W    (ADDR_W),
    .MA_W      (MA_W),
    .ROW_LSB   (ROW_LSB),
    .BANK_LSB  (BANK_LSB),
    .BANK_W    (BANK_W),
    .MIN_LINES (MIN_LINES)
  ) u_split (
    .addr (req_addr),
    .size (req_size),
    .row  (req_row),
    .col  (req_col),
    .bank (req_bank)
  );

  dram_strobe_seq #(
    .MA_W    (MA_W),
    .RCD_CYC (RCD_CYC),
    .CAS_CYC (CAS_CYC),
    .PRE_CYC (PRE_CYC)
  ) u_seq (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .row   (req_row),
    .col   (req_col),
    .ready (req_ready),
    .ma    (dram_ma),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .done  (acc_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bank_q <= '0;
    end else if (start) begin
      bank_q <= req_bank;
    end
  end

  assign dram_bank = bank_q;

endmodule

// File: rtl/dram_addr_mux_chk.sv
module dram_addr_mux_chk #(
  parameter int MA_W   = 11,
  parameter int BANK_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic [MA_W-1:0]   dram_ma,
  input logic [BANK_W-1:0] dram_bank,
  input logic              ras_n,
  input logic              cas_n,
  input logic              acc_done
);

  AST_ACCEPT_OPENS_ROW: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (!ras_n && cas_n)); // R5

  AST_CAS_INSIDE_RAS: assert property (@(posedge clk) disable iff (rst)
    !cas_n |-> !ras_n); // R5

  AST_MA_PARKED: assert property (@(posedge clk) disable iff (rst)
    (ras_n && cas_n) |-> (dram_ma == '0)); // R5

  AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (ras_n && cas_n)); // R7

  AST_DONE_AT_RELEASE: assert property (@(posedge clk) disable iff (rst)
    acc_done |-> (ras_n && cas_n && $past(!ras_n) && $past(!cas_n) && !req_ready)); // R6

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    acc_done |=> !acc_done); // R6

  AST_BANK_HELD: assert property (@(posedge clk) disable iff (rst)
    (!ras_n && $past(!ras_n)) |-> $stable(dram_bank)); // R9

endmodule

bind dram_addr_mux dram_addr_mux_chk #(
  .MA_W   (MA_W),
  .BANK_W (BANK_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .dram_ma   (dram_ma),
  .dram_bank (dram_bank),
  .ras_n     (ras_n),
  .cas_n     (cas_n),
  .acc_done  (acc_done)
);

// File: tb/dram_addr_mux_bench.sv
module dram_addr_mux_bench;

  localparam int CLK_PERIOD = 10;
  localparam int RCD = 2;
  localparam int CAS = 2;
  localparam int PRE = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [23:0] req_addr = '0;
  logic        req_ready;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_bank = '0;
  logic [1:0]  cfg_size = '0;
  logic [10:0] dram_ma;
  logic [1:0]  dram_bank;
  logic        ras_n;
  logic        cas_n;
  logic        acc_done;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [1:0] sz_model [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_addr_mux #(
    .RCD_CYC (RCD),
    .CAS_CYC (CAS),
    .PRE_CYC (PRE)
  ) u_dram_addr_mux (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .req_ready (req_ready),
    .cfg_we    (cfg_we),
    .cfg_bank  (cfg_bank),
    .cfg_size  (cfg_size),
    .dram_ma   (dram_ma),
    .dram_bank (dram_bank),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .acc_done  (acc_done)
  );

  function automatic logic [10:0] lines_mask(logic [1:0] sz);
    return 11'((32'd1 << (8 + int'(sz))) - 1);
  endfunction

  function automatic logic [10:0] exp_row(logic [23:0] a, logic [1:0] sz);
    return a[23:13] & lines_mask(sz);
  endfunction

  function automatic logic [10:0] exp_col(logic [23:0] a, logic [1:0] sz);
    return a[10:0] & lines_mask(sz);
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic write_cfg(logic [1:0] b, logic [1:0] s);
    @(negedge clk);
    cfg_we = 1'b1; cfg_bank = b; cfg_size = s;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
    sz_model[b] = s;
  endtask

  // Runs one access; with disturb set, raises a request and a config write mid-access.
  task automatic run_access(logic [23:0] a, bit disturb);
    logic [1:0]  b;
    logic [1:0]  sz;
    logic [10:0] erow;
    logic [10:0] ecol;
    string       map_tag;
    int          gap;
    b = a[12:11];
    sz = sz_model[b];
    erow = exp_row(a, sz);
    ecol = exp_col(a, sz);
    map_tag = (sz == 2'd3) ? "R3" : "R4";
    @(negedge clk);
    chk(req_ready === 1'b1, "R7 ready before request", 32'(req_ready), 32'd1);
    req_valid = 1'b1; req_addr = a;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(!ras_n && cas_n, "R5 row strobe after accept", {30'd0, ras_n, cas_n}, 32'd1);
    chk(dram_ma === erow, {map_tag, " row"}, 32'(dram_ma), 32'(erow));
    chk(dram_bank === b, "R2 bank select", 32'(dram_bank), 32'(b));
    if (disturb) begin
      req_valid = 1'b1; req_addr = ~a;
      cfg_we = 1'b1; cfg_bank = b; cfg_size = sz + 2'd1;
    end
    for (int k = 1; k < RCD; k++) begin
      @(negedge clk);
      chk(!ras_n && cas_n && dram_ma === erow, "R5 row held", 32'(dram_ma), 32'(erow));
    end
    @(negedge clk);
    req_valid = 1'b0; cfg_we = 1'b0;
    chk(!ras_n && !cas_n, "R5 column strobe", {30'd0, ras_n, cas_n}, 32'd0);
    chk(dram_ma === ecol, {map_tag, " column"}, 32'(dram_ma), 32'(ecol));
    chk(dram_bank === b, "R9 bank held", 32'(dram_bank), 32'(b));
    for (int k = 1; k < CAS; k++) begin
      @(negedge clk);
      chk(!ras_n && !cas_n && dram_ma === ecol, "R5 column held", 32'(dram_ma), 32'(ecol));
    end
    @(negedge clk);
    chk(ras_n && cas_n, "R6 strobes released together", {30'd0, ras_n, cas_n}, 32'd3);
    chk(acc_done === 1'b1, "R6 done pulse", 32'(acc_done), 32'd1);
    chk(dram_ma === 11'd0, "R5 address parked", 32'(dram_ma), 32'd0);
    gap = 0;
    while (!req_ready && gap < 20) begin
      @(negedge clk);
      gap++;
      chk(acc_done === 1'b0, "R6 done single cycle", 32'(acc_done), 32'd0);
    end
    chk(gap == PRE, "R6 precharge gap", 32'(gap), 32'(PRE));
    chk(ras_n === 1'b1, "R7 no extra access", 32'(ras_n), 32'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed_init;
    seed_init = $urandom(32'h5EED_1234);
    for (int i = 0; i < 4; i++) sz_model[i] = 2'd3;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(ras_n && cas_n, "R1 strobes idle", {30'd0, ras_n, cas_n}, 32'd3);
    chk(dram_ma === 11'd0, "R1 address zero", 32'(dram_ma), 32'd0);
    chk(req_ready === 1'b1 && acc_done === 1'b0, "R1 ready and no done",
        {30'd0, req_ready, acc_done}, 32'd2);

    // R1: every bank decodes as 4M out of reset (full 11-line row).
    for (int b = 0; b < 4; b++) run_access({11'h7FF, 2'(b), 11'h7FF}, 1'b0);
    run_access(24'h800000, 1'b0);
    run_access(24'h001800, 1'b0);

    // R4: aliasing of the top row line for each smaller size, bank 1.
    write_cfg(2'd1, 2'd2);
    run_access(24'h800800, 1'b0);
    write_cfg(2'd1, 2'd1);
    run_access(24'h400800, 1'b0);
    write_cfg(2'd1, 2'd0);
    run_access(24'h200800, 1'b0);
    run_access(24'h100FFF, 1'b0);

    // R9: distinct sizes per bank, all-ones address shows each width.
    write_cfg(2'd0, 2'd0);
    write_cfg(2'd1, 2'd1);
    write_cfg(2'd2, 2'd2);
    write_cfg(2'd3, 2'd3);
    for (int b = 0; b < 4; b++) run_access({11'h7FF, 2'(b), 11'h7FF}, 1'b0);

    // R7 / R8: requests and config writes during an access are ignored.
    run_access(24'h123456 | 24'h001000, 1'b1);
    run_access(24'hFFF7FF & 24'hFFF7FF | 24'h001000, 1'b0);
    run_access(24'hABC800 & 24'hFFE7FF, 1'b1);
    run_access(24'hFFE7FF, 1'b0);

    // Random mix.
    for (int n = 0; n < 300; n++) begin
      if (($urandom % 8) == 0) write_cfg(2'($urandom), 2'($urandom));
      run_access(24'($urandom), (($urandom % 16) == 0));
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule